// File: doc/BRIEF.md
# Reference clock switch

This block picks one of two unrelated reference clocks, an internal clock and an external clock, and drives the selected one onto a single output clock that feeds the divider chain. A select level chooses the source. The block moves between sources without glitches. Every high and low phase on the output is a whole phase of one of the sources, or a low gap during a switch.

The two directions of a switch work differently. Going from internal to external is edge driven. The select change is captured on falling internal-clock edges. The internal leg then releases at a falling internal edge. The external leg takes over only at a falling external edge, after it has seen that release. Going from external to internal is level driven. Once the internal side has seen the select high, the external leg is cleared as soon as the external clock is low. No external edge is needed, so the switch completes even when the external clock has stopped low. The internal leg then takes over at a falling internal edge, so the first output pulse is an internal rising edge. If the external clock is stuck high, the switch back cannot finish and the output stays high.

The select input is asynchronous. It must stay stable for at least eight periods of the slower running source between changes. There is no data stream, so every pin is a plain level or clock.

Top module: `refclk_switch`

## Requirements
- R1: While `rst_n` is low, the output runs from the internal clock and the external leg is off.
- R2: `sel_int` high selects the internal clock and `sel_int` low selects the external clock. Once the switch has settled, the output rate equals the rate of the selected source.
- R3: A falling `sel_int` is taken in on falling internal-clock edges through a two-stage synchronizer. The internal leg releases at a falling internal edge. The external leg is enabled only at a falling external edge, after the internal release has been seen and while the request still points to external.
- R4: After a rising `sel_int`, the external leg is cleared only while `ext_clk` is low. The internal leg is enabled at a falling internal edge, after the external release has been seen.
- R5: If the external clock has stopped low, a switch from external to internal still completes, and the output then runs at the internal rate.
- R6: If the external clock is stuck high, a switch to internal cannot complete: the output stays high with no rising edges. Once the external clock resumes, the switch finishes.
- R7: The internal and external legs are never enabled at the same time.
- R8: Every output high phase and low phase, including the gap during a switch, lasts at least the shorter of the two source half-periods.
- R9: Under repeated select changes, held as required, across several external rates, R8 holds and the output ends on the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal reference clock |
| ext_clk | input | 1 | External reference clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_int | input | 1 | Source select level: 1 internal, 0 external |
| clk_out | output | 1 | Selected reference clock |

## Verification
The output is tried with the external clock running slower than, close to, and faster than the internal clock. Rate counts over a fixed window show which source is driving the output, and the shortest observed phase exposes any runt pulse or overlap at the handoff. The external clock is also parked low and then parked high during a switch back to internal. These two cases separate the level-sensed release, which must finish, from the stuck case, which must hold the output high until the external clock resumes. A run of select toggles with random hold times then checks that the phase bound survives handoffs at arbitrary relative phases of the two sources.

// File: rtl/refclk_switch_pkg.sv
package refclk_switch_pkg;
  // Level of the select input that asks for the internal source.
  localparam logic SEL_INTERNAL = 1'b1;
  // Default number of synchronizer flops per crossing.
  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/refclk_sync.sv
// Falling-edge synchronizer chain with an active-high asynchronous load.
module refclk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(negedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{RST_VAL}};
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refclk_int_leg.sv
// Internal-clock leg: takes in the select on falling internal edges and
// moves its enable only while the internal clock is low.
module refclk_int_leg
  import refclk_switch_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH_DEF
) (
  input  logic int_clk,
  input  logic rst_n,
  input  logic sel_int,
  input  logic ext_on,
  output logic int_en,
  output logic want_int
);
  logic arst;
  logic ext_seen;

  assign arst = ~rst_n;

  refclk_sync #(.STAGES(STAGES), .RST_VAL(SEL_INTERNAL)) u_sel_sync (
    .clk(int_clk), .arst(arst), .d(sel_int), .q(want_int)
  );

  refclk_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ext_sync (
    .clk(int_clk), .arst(arst), .d(ext_on), .q(ext_seen)
  );

  // Enable only when asked for and the other leg is seen off (R3, R4).
  always_ff @(negedge int_clk or posedge arst) begin
    if (arst) int_en <= 1'b1;
    else      int_en <= want_int & ~ext_seen;
  end
endmodule

// File: rtl/refclk_ext_leg.sv
// External-clock leg: enabled on falling external edges; cleared by a level
// condition so that a stopped-low external clock can still be released.
module refclk_ext_leg
  import refclk_switch_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH_DEF
) (
  input  logic ext_clk,
  input  logic rst_n,
  input  logic sel_int,
  input  logic int_on,
  input  logic want_int,
  output logic ext_en
);
  logic kill;
  logic clr;
  logic rst_a;
  logic sel_seen;
  logic int_seen;

  // Level-sensed release: internal side wants control and ext is low (R4).
  assign kill  = want_int & ~ext_clk;
  assign clr   = ~rst_n | kill;
  assign rst_a = ~rst_n;

  // The select chain is also forced to "internal" by the release, so a stale
  // low select cannot re-enable this leg after the clear lifts.
  refclk_sync #(.STAGES(STAGES), .RST_VAL(SEL_INTERNAL)) u_sel_sync (
    .clk(ext_clk), .arst(clr), .d(sel_int), .q(sel_seen)
  );

  refclk_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(ext_clk), .arst(rst_a), .d(int_on), .q(int_seen)
  );

  always_ff @(negedge ext_clk or posedge clr) begin
    if (clr) ext_en <= 1'b0;
    else     ext_en <= ~sel_seen & ~int_seen;
  end
endmodule

// File: rtl/refclk_switch.sv
// Glitch-free two-source reference clock switch.
module refclk_switch
  import refclk_switch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic rst_n,
  input  logic sel_int,
  output logic clk_out
);
  logic int_en;
  logic ext_en;
  logic want_int;

  refclk_int_leg #(.STAGES(SYNC_STAGES)) u_int_leg (
    .int_clk (int_clk),
    .rst_n   (rst_n),
    .sel_int (sel_int),
    .ext_on  (ext_en),
    .int_en  (int_en),
    .want_int(want_int)
  );

  refclk_ext_leg #(.STAGES(SYNC_STAGES)) u_ext_leg (
    .ext_clk (ext_clk),
    .rst_n   (rst_n),
    .sel_int (sel_int),
    .int_on  (int_en),
    .want_int(want_int),
    .ext_en  (ext_en)
  );

  // Each enable only moves while its own clock is low, so the OR is clean.
  assign clk_out = (int_clk & int_en) | (ext_clk & ext_en);
endmodule

// File: rtl/refclk_switch_chk.sv
module refclk_switch_chk (
  input logic int_clk,
  input logic ext_clk,
  input logic rst_n,
  input logic int_en,
  input logic ext_en,
  input logic want_int
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge int_clk)
    !rst_n |-> (int_en && !ext_en));

  // R7: never both legs on, seen from either clock
  a_r7_one_leg_int: assert property (@(posedge int_clk) disable iff (!rst_n)
    !(int_en && ext_en));
  a_r7_one_leg_ext: assert property (@(posedge ext_clk) disable iff (!rst_n)
    !(int_en && ext_en));

  // R4: internal leg turns on only when requested and external leg is off
  a_r4_int_takeover: assert property (@(posedge int_clk) disable iff (!rst_n)
    $rose(int_en) |-> (want_int && !ext_en));

  // R3: external leg turns on only after internal released and no request back
  a_r3_ext_takeover: assert property (@(posedge ext_clk) disable iff (!rst_n)
    $rose(ext_en) |-> (!int_en && !want_int));

  // R4: while internal is requested, external leg cannot newly turn on
  a_r4_no_ext_rearm: assert property (@(posedge ext_clk) disable iff (!rst_n)
    (want_int && !ext_en) |=> !$rose(ext_en) || !want_int);
endmodule

bind refclk_switch refclk_switch_chk chk_i (
  .int_clk (int_clk),
  .ext_clk (ext_clk),
  .rst_n   (rst_n),
  .int_en  (int_en),
  .ext_en  (ext_en),
  .want_int(want_int)
);

// File: tb/refclk_switch_tb_top.sv
`timescale 1ns/1ps
module refclk_switch_tb_top;
  logic tb_clk = 1'b0;
  logic int_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic rst_n = 1'b1;
  logic sel_int = 1'b1;
  logic clk_out;

  real int_half = 5.0;
  real ext_half = 7.0;
  bit  ext_run  = 1'b1;
  bit  ext_park = 1'b0;

  int vectors = 0;
  int miscmp  = 0;
  int rises   = 0;
  int cyc     = 0;

  bit  mon_on = 1'b0;
  real last_t = -1.0;
  real min_ph = 1.0e9;

  refclk_switch dut_i (
    .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .sel_int(sel_int), .clk_out(clk_out)
  );

  always #2 tb_clk = ~tb_clk;

  initial forever #(int_half) int_clk = ~int_clk;

  initial forever begin
    if (ext_run) begin
      ext_clk = 1'b1; #(ext_half);
      ext_clk = 1'b0; #(ext_half);
    end else begin
      ext_clk = ext_park; #1;
    end
  end

  always @(posedge clk_out) rises++;

  always @(clk_out) begin
    if (mon_on) begin
      if (last_t >= 0.0 && ($realtime - last_t) < min_ph) min_ph = $realtime - last_t;
      last_t = $realtime;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge tb_clk) begin
    cyc++;
    if (cyc > 150000) begin
      vectors++; miscmp++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk_int(string req, int act, int exp, int tol);
    vectors++;
    if (act > exp + tol || act < exp - tol) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic chk_ge(string req, real act, real lim);
    vectors++;
    if (act < lim - 0.001) begin
      miscmp++;
      $display("FAIL %s: actual %0.3f expected >= %0.3f", req, act, lim);
    end
  endtask

  task automatic rate(string req, real per);
    int n0;
    n0 = rises;
    #(280.0);
    chk_int(req, rises - n0, int'(280.0 / per), 1);
  endtask

  task automatic mon_start();
    mon_on = 1'b1; last_t = -1.0; min_ph = 1.0e9;
  endtask

  function automatic real lim_now();
    return (int_half < ext_half) ? int_half : ext_half;
  endfunction

  // R1: reset behaviour
  task automatic t_reset();
    #1 rst_n = 1'b0;
    #20;
    rate("R1 reset runs internal", 2.0 * int_half);
    #3 rst_n = 1'b1;
    #200;
  endtask

  // R2: internal selected after reset
  task automatic t_internal();
    mon_start();
    sel_int = 1'b1;
    #300;
    rate("R2 internal rate", 2.0 * int_half);
  endtask

  // R3: edge-driven switch to external
  task automatic t_to_ext();
    sel_int = 1'b0;
    #400;
    rate("R3 external rate after switch", 2.0 * ext_half);
    chk_ge("R8 phase during switch to external", min_ph, lim_now());
  endtask

  // R4: level-driven switch back to internal
  task automatic t_to_int();
    mon_start();
    sel_int = 1'b1;
    #400;
    rate("R4 internal rate after switch back", 2.0 * int_half);
    chk_ge("R8 phase during switch to internal", min_ph, lim_now());
  endtask

  // R5: external stopped low, switch back still completes
  task automatic t_ext_stopped_low();
    sel_int = 1'b0;
    #400;
    ext_park = 1'b0; ext_run = 1'b0;
    #100;
    mon_start();
    sel_int = 1'b1;
    #300;
    rate("R5 internal rate with external stopped low", 2.0 * int_half);
    chk_ge("R8 phase with external stopped low", min_ph, lim_now());
    ext_run = 1'b1;
    #100;
  endtask

  // R6: external stuck high, switch cannot finish until it resumes
  task automatic t_ext_stuck_high();
    int n0;
    sel_int = 1'b0;
    #400;
    ext_park = 1'b1; ext_run = 1'b0;
    #100;
    sel_int = 1'b1;
    #300;
    @(negedge tb_clk);
    n0 = rises;
    chk_int("R6 output held high while external stuck", int'(clk_out), 1, 0);
    #200;
    @(negedge tb_clk);
    chk_int("R6 no rising edges while external stuck", rises - n0, 0, 0);
    mon_start();
    ext_run = 1'b1;
    #300;
    rate("R6 switch completes once external resumes", 2.0 * int_half);
    chk_ge("R8 phase on release after stuck high", min_ph, lim_now());
  endtask

  // R9: random toggles across several external rates
  task automatic t_random();
    real halves[4] = '{3.0, 4.5, 8.0, 11.0};
    for (int k = 0; k < 4; k++) begin
      sel_int = 1'b1;
      #400;
      ext_half = halves[k];
      #100;
      mon_start();
      for (int j = 0; j < 8; j++) begin
        sel_int = ~sel_int;
        #(200 + ($urandom % 200));
      end
      #300;
      chk_ge("R9 phase bound under random toggles", min_ph, lim_now());
      rate("R9 output ends on selected source",
           sel_int ? 2.0 * int_half : 2.0 * ext_half);
    end
    sel_int = 1'b1;
    #300;
  endtask

  initial begin
    void'($urandom(11));
    t_reset();
    t_internal();
    t_to_ext();
    t_to_int();
    t_ext_stopped_low();
    t_ext_stuck_high();
    t_random();
    finish_run();
  end
endmodule